// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block translates a virtual address into a physical address for a processor memory unit. It is fully associative and compares every stored mapping in parallel. Each stored mapping covers two neighbouring virtual pages, an even one and an odd one. Each of those pages has its own physical frame and its own attribute bits: valid, dirty (write allowed), execute-inhibit and read-inhibit. The page size is set per mapping by a variable size mask. The smallest page is 4 KiB.

A request gives a virtual address, the current address-space tag, a wider map tag, a mode select that chooses between the two tags, and an access kind. One clock later the block returns a result code, the physical address and three permission bits, marked by a one-cycle response strobe. A simple write port loads mappings by index. A configuration input limits how many of the stored mappings take part in a lookup.

Top module: `tlbl_lookup_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid` is low and every stored mapping is invalidated, so any lookup returns NOMATCH (code 1) until a mapping is written.
- R2: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next clock. Back-to-back requests give back-to-back responses, and there is no response without a request.
- R3: A mapping hits only when three conditions all hold: its global bit is set or its tag equals the request tag; its VPN, with the bits under its effective mask cleared, equals the address with the same bits cleared; and its invalidate bit is clear. When no mapping hits, the code is NOMATCH (1).
- R4: With `mmid_mode` = 1 the 16-bit map tags are compared. With `mmid_mode` = 0 the 8-bit address-space tags are compared.
- R5: The effective mask is the size mask ORed with 0x1FFF. The even or odd half is chosen by the highest bit set in the effective mask, which is bit 12 for 4 KiB pages and bit 14 for 16 KiB pages. The physical address is the half's frame ORed with the address bits under the effective mask shifted right by one.
- R6: If the selected half is not valid, the code is INVALID (2). This takes precedence over all other checks.
- R7: A fetch (`req_acc` = 0) to a half with execute-inhibit set gives XI (4). A load (`req_acc` = 1) to a half with read-inhibit set gives RI (5).
- R8: A store (`req_acc` = 2) to a half whose dirty bit is clear gives DIRTY (3). Loads and fetches succeed with the dirty bit clear.
- R9: On MATCH (0), `rsp_prot` bit 0 (read) is 1, bit 1 (write) equals the dirty bit, and bit 2 (execute) is the inverse of execute-inhibit. On any other code, `rsp_prot` and `rsp_pa` are zero.
- R10: Only mappings with index at most `cfg_last` take part in a lookup. The limit is inclusive.
- R11: When several mappings hit, the one with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one mapping |
| wr_idx | input | IDX_W | Index of the mapping to write |
| wr_entry | input | ENT_W | Mapping record, MSB first: vpn, size mask, asid, mmid, global, invalidate, odd half {frame, v, d, xi, ri}, even half |
| cfg_last | input | 6 | Highest mapping index that takes part in a lookup |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space tag |
| req_mmid | input | 16 | Current wide map tag |
| mmid_mode | input | 1 | 1 selects wide-tag comparison |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response strobe, one clock after a request |
| rsp_code | output | 3 | Result code: 0 match, 1 nomatch, 2 invalid, 3 dirty, 4 XI, 5 RI |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 3 | Permissions {execute, write, read} |

## Verification
The lookup has only one register stage, so a corrupted mapping or a wrong half select appears at the ports on the very next response. It shows as a wrong code, a frame from the wrong half or a wrong permission bit. A mapping that survives reset without being invalidated is detected by the first lookup after reset. A broken priority or count limit appears as soon as two mappings overlap or a mapping sits just above or below `cfg_last`. A lost or extra response strobe is visible in the cycle that follows the request.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

    parameter int ADDR_W     = 32;
    parameter int ASID_W     = 8;
    parameter int MMID_W     = 16;
    parameter int PAGE_SHIFT = 12;
    parameter int CFG_W      = 6;

    // two minimum pages plus their offset are always under the mask
    localparam logic [ADDR_W-1:0] PAIR_MASK =
        ADDR_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        RES_MATCH   = 3'd0,
        RES_NOMATCH = 3'd1,
        RES_INVALID = 3'd2,
        RES_DIRTY   = 3'd3,
        RES_XI      = 3'd4,
        RES_RI      = 3'd5
    } res_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pfn;
        logic              v;
        logic              d;
        logic              xi;
        logic              ri;
    } half_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vpn;
        logic [ADDR_W-1:0] pmask;
        logic [ASID_W-1:0] asid;
        logic [MMID_W-1:0] mmid;
        logic              g;
        logic              ehinv;
        half_t             odd;
        half_t             even;
    } entry_t;

    localparam int ENT_W = $bits(entry_t);

    typedef struct packed {
        res_e              code;
        logic [ADDR_W-1:0] pa;
        logic [2:0]        prot;
    } resp_t;

    function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] pm);
        return pm | PAIR_MASK;
    endfunction

endpackage

// File: rtl/tlbl_entry_cmp.sv
module tlbl_entry_cmp
    import tlbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEG_MASK = '1
) (
    input  entry_t             ent,
    input  logic               active,
    input  logic [ADDR_W-1:0]  va,
    input  logic [ASID_W-1:0]  asid,
    input  logic [MMID_W-1:0]  mmid,
    input  logic               mmid_mode,
    output logic               hit
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] tag;
    logic              id_ok;

    always_comb begin
        mask  = eff_mask(ent.pmask);
        tag   = va & ~mask & SEG_MASK;
        id_ok = ent.g || (mmid_mode ? (ent.mmid == mmid) : (ent.asid == asid));
        hit   = active && id_ok && ((ent.vpn & ~mask) == tag) && !ent.ehinv;
    end
endmodule

// File: rtl/tlbl_prio_sel.sv
module tlbl_prio_sel #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               any,
    output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] idx
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    always_comb begin
        any = |hits;
        idx = '0;
        // scan downward so the lowest hitting index is the last one kept
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlbl_perm.sv
module tlbl_perm
    import tlbl_pkg::*;
(
    input  logic              hit,
    input  logic [ADDR_W-1:0] pmask,
    input  half_t             even_h,
    input  half_t             odd_h,
    input  logic [ADDR_W-1:0] va,
    input  acc_e              acc,
    output resp_t             resp
);
    logic [ADDR_W-1:0] mask;
    logic              odd;
    half_t             h;

    always_comb begin
        mask = eff_mask(pmask);
        odd  = |(va & mask & ~(mask >> 1));
        h    = odd ? odd_h : even_h;

        resp.code = RES_NOMATCH;
        resp.pa   = '0;
        resp.prot = 3'b000;
        if (hit) begin
            if (!h.v)                           resp.code = RES_INVALID;
            else if (acc == ACC_FETCH && h.xi)  resp.code = RES_XI;
            else if (acc == ACC_LOAD  && h.ri)  resp.code = RES_RI;
            else if (acc == ACC_STORE && !h.d)  resp.code = RES_DIRTY;
            else begin
                resp.code = RES_MATCH;
                resp.pa   = h.pfn | (va & (mask >> 1));
                resp.prot = {!h.xi, h.d, 1'b1};
            end
        end
    end
endmodule

// File: rtl/tlbl_lookup_unit.sv
module tlbl_lookup_unit
    import tlbl_pkg::*;
#(
    parameter int                ENTRIES  = 8,
    parameter logic [ADDR_W-1:0] SEG_MASK = '1,
    localparam int               IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [CFG_W-1:0]  cfg_last,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [MMID_W-1:0] req_mmid,
    input  logic              mmid_mode,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic [2:0]        rsp_prot
);
    entry_t             tbl [ENTRIES];
    logic [ENTRIES-1:0] hits;
    logic               any_hit;
    logic [IDX_W-1:0]   sel_idx;
    resp_t              resp_c;
    resp_t              resp_q;
    logic               valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i]       <= '0;
                tbl[i].ehinv <= 1'b1;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= entry_t'(wr_entry);
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        localparam logic [CFG_W:0] IDX_C = (CFG_W + 1)'(g);
        tlbl_entry_cmp #(.SEG_MASK(SEG_MASK)) cmp_i (
            .ent       (tbl[g]),
            .active    (IDX_C <= {1'b0, cfg_last}),
            .va        (req_va),
            .asid      (req_asid),
            .mmid      (req_mmid),
            .mmid_mode (mmid_mode),
            .hit       (hits[g])
        );
    end

    tlbl_prio_sel #(.ENTRIES(ENTRIES)) prio_i (
        .hits (hits),
        .any  (any_hit),
        .idx  (sel_idx)
    );

    tlbl_perm perm_i (
        .hit    (any_hit),
        .pmask  (tbl[sel_idx].pmask),
        .even_h (tbl[sel_idx].even),
        .odd_h  (tbl[sel_idx].odd),
        .va     (req_va),
        .acc    (acc_e'(req_acc)),
        .resp   (resp_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q     <= 1'b0;
            resp_q.code <= RES_NOMATCH;
            resp_q.pa   <= '0;
            resp_q.prot <= 3'b000;
        end else begin
            valid_q <= req_valid;
            if (req_valid) resp_q <= resp_c;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_code  = resp_q.code;
    assign rsp_pa    = resp_q.pa;
    assign rsp_prot  = resp_q.prot;
endmodule

// File: rtl/tlbl_lookup_chk.sv
module tlbl_lookup_chk
    import tlbl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_acc,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic [2:0]        rsp_prot
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_code <= 3'd5); // R3
    AST_FAIL_CLEARS_OUT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 3'd0) |-> (rsp_prot == 3'b000 && rsp_pa == '0)); // R9
    AST_MATCH_READABLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd0) |-> rsp_prot[0]); // R9
    AST_STORE_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd0 && $past(req_acc) == 2'd2) |-> rsp_prot[1]); // R8
    AST_FETCH_EXECUTABLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd0 && $past(req_acc) == 2'd0) |-> rsp_prot[2]); // R7
    AST_XI_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd4) |-> $past(req_acc) == 2'd0); // R7
    AST_RI_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd5) |-> $past(req_acc) == 2'd1); // R7
    AST_DIRTY_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 3'd3) |-> $past(req_acc) == 2'd2); // R8
endmodule

bind tlbl_lookup_unit tlbl_lookup_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_acc   (req_acc),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_pa    (rsp_pa),
    .rsp_prot  (rsp_prot)
);

// File: tb/tlbl_lookup_unit_tb_top.sv
module tlbl_lookup_unit_tb_top;
    import tlbl_pkg::*;

    localparam int IDX_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ENT_W-1:0]  wr_entry = '0;
    logic [CFG_W-1:0]  cfg_last = 6'd7;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_va = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [MMID_W-1:0] req_mmid = '0;
    logic              mmid_mode = 1'b0;
    logic [1:0]        req_acc = 2'd1;
    logic              rsp_valid;
    logic [2:0]        rsp_code;
    logic [ADDR_W-1:0] rsp_pa;
    logic [2:0]        rsp_prot;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    tlbl_lookup_unit #(.ENTRIES(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .cfg_last(cfg_last), .req_valid(req_valid), .req_va(req_va),
        .req_asid(req_asid), .req_mmid(req_mmid), .mmid_mode(mmid_mode),
        .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_pa(rsp_pa), .rsp_prot(rsp_prot)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic half_t mk_half(input logic [31:0] pfn, input logic v,
                                      input logic d, input logic xi, input logic ri);
        half_t h;
        h.pfn = pfn; h.v = v; h.d = d; h.xi = xi; h.ri = ri;
        return h;
    endfunction

    function automatic entry_t mk_ent(input logic [31:0] vpn, input logic [31:0] pm,
                                      input logic [7:0] asid, input logic [15:0] mmid,
                                      input logic g, input logic inv,
                                      input half_t ev, input half_t od);
        entry_t e;
        e.vpn = vpn; e.pmask = pm; e.asid = asid; e.mmid = mmid;
        e.g = g; e.ehinv = inv; e.even = ev; e.odd = od;
        return e;
    endfunction

    task automatic write_ent(input int idx, input entry_t e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_entry = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                          input logic [15:0] mmid, input logic mode, input acc_e acc,
                          input res_e exp_code, input logic [31:0] exp_pa,
                          input logic [2:0] exp_prot);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asid = asid; req_mmid = mmid;
        mmid_mode = mode; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(req, "code", 64'(rsp_code), 64'(exp_code));
        check(req, "pa", 64'(rsp_pa), 64'(exp_pa));
        check(req, "prot", 64'(rsp_prot), 64'(exp_prot));
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        // zeroed mapping would match va 0 / tag 0 unless invalidated by reset
        lookup("R1", 32'h0000_0010, 8'd0, 16'd0, 1'b0, ACC_LOAD, RES_NOMATCH, 32'd0, 3'b000);
    endtask

    task automatic t_small_pair;
        write_ent(0, mk_ent(32'h0040_0000, 32'd0, 8'd5, 16'd0, 1'b0, 1'b0,
                            mk_half(32'h1000_0000, 1, 1, 0, 0),
                            mk_half(32'h2000_0000, 1, 0, 1, 0)));
        lookup("R5", 32'h0040_0123, 8'd5, 16'd0, 1'b0, ACC_LOAD,  RES_MATCH, 32'h1000_0123, 3'b111);
        lookup("R8", 32'h0040_1456, 8'd5, 16'd0, 1'b0, ACC_LOAD,  RES_MATCH, 32'h2000_0456, 3'b001);
        lookup("R8", 32'h0040_1456, 8'd5, 16'd0, 1'b0, ACC_STORE, RES_DIRTY, 32'd0, 3'b000);
        lookup("R9", 32'h0040_0FFC, 8'd5, 16'd0, 1'b0, ACC_STORE, RES_MATCH, 32'h1000_0FFC, 3'b111);
        lookup("R7", 32'h0040_1000, 8'd5, 16'd0, 1'b0, ACC_FETCH, RES_XI,    32'd0, 3'b000);
        lookup("R3", 32'h0040_0123, 8'd6, 16'd0, 1'b0, ACC_LOAD,  RES_NOMATCH, 32'd0, 3'b000);
        lookup("R3", 32'h0040_2000, 8'd5, 16'd0, 1'b0, ACC_LOAD,  RES_NOMATCH, 32'd0, 3'b000);
    endtask

    task automatic t_large_page;
        // 16 KiB pages: mask 0x6000, half select is bit 14
        write_ent(1, mk_ent(32'h0080_0000, 32'h0000_6000, 8'd0, 16'd0, 1'b1, 1'b0,
                            mk_half(32'h7000_0000, 0, 1, 1, 1),
                            mk_half(32'h3000_0000, 1, 1, 0, 1)));
        lookup("R6", 32'h0080_3ABC, 8'd9, 16'd0, 1'b0, ACC_FETCH, RES_INVALID, 32'd0, 3'b000);
        lookup("R7", 32'h0080_4ABC, 8'd9, 16'd0, 1'b0, ACC_LOAD,  RES_RI, 32'd0, 3'b000);
        lookup("R5", 32'h0080_7ABC, 8'd9, 16'd0, 1'b0, ACC_FETCH, RES_MATCH, 32'h3000_3ABC, 3'b111);
        lookup("R3", 32'h0080_7ABC, 8'd9, 16'd0, 1'b1, ACC_STORE, RES_MATCH, 32'h3000_3ABC, 3'b111);
    endtask

    task automatic t_id_modes;
        write_ent(2, mk_ent(32'h00C0_0000, 32'd0, 8'd3, 16'h1234, 1'b0, 1'b0,
                            mk_half(32'h4000_0000, 1, 1, 0, 0),
                            mk_half(32'h4800_0000, 1, 1, 0, 0)));
        lookup("R4", 32'h00C0_0044, 8'd3, 16'h9999, 1'b0, ACC_LOAD, RES_MATCH, 32'h4000_0044, 3'b111);
        lookup("R4", 32'h00C0_0044, 8'd7, 16'h1234, 1'b1, ACC_LOAD, RES_MATCH, 32'h4000_0044, 3'b111);
        lookup("R4", 32'h00C0_0044, 8'd3, 16'h1235, 1'b1, ACC_LOAD, RES_NOMATCH, 32'd0, 3'b000);
        lookup("R4", 32'h00C0_0044, 8'd7, 16'h1234, 1'b0, ACC_LOAD, RES_NOMATCH, 32'd0, 3'b000);
    endtask

    task automatic t_priority_window;
        write_ent(3, mk_ent(32'h0040_0000, 32'd0, 8'd5, 16'd0, 1'b0, 1'b0,
                            mk_half(32'h5000_0000, 1, 1, 0, 0),
                            mk_half(32'h5800_0000, 1, 1, 0, 0)));
        lookup("R11", 32'h0040_0010, 8'd5, 16'd0, 1'b0, ACC_LOAD, RES_MATCH, 32'h1000_0010, 3'b111);
        write_ent(0, mk_ent(32'h0040_0000, 32'd0, 8'd5, 16'd0, 1'b0, 1'b1,
                            mk_half(32'h1000_0000, 1, 1, 0, 0),
                            mk_half(32'h2000_0000, 1, 0, 1, 0)));
        lookup("R3", 32'h0040_0010, 8'd5, 16'd0, 1'b0, ACC_LOAD, RES_MATCH, 32'h5000_0010, 3'b111);
        cfg_last = 6'd2;
        lookup("R10", 32'h0040_0010, 8'd5, 16'd0, 1'b0, ACC_LOAD, RES_NOMATCH, 32'd0, 3'b000);
        cfg_last = 6'd3;
        lookup("R10", 32'h0040_0010, 8'd5, 16'd0, 1'b0, ACC_LOAD, RES_MATCH, 32'h5000_0010, 3'b111);
        cfg_last = 6'd7;
    endtask

    task automatic t_pulse;
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h00C0_0100; req_asid = 8'd3; mmid_mode = 1'b0;
        req_acc = ACC_LOAD;
        @(negedge clk);
        check("R2", "first of pair valid", 64'(rsp_valid), 64'd1);
        check("R2", "first of pair pa", 64'(rsp_pa), 64'h4000_0100);
        req_va = 32'h00C0_1200;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "second of pair valid", 64'(rsp_valid), 64'd1);
        check("R2", "second of pair pa", 64'(rsp_pa), 64'h4800_0200);
        @(negedge clk);
        check("R2", "strobe ends", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_small_pair();
        t_large_page();
        t_id_modes();
        t_priority_window();
        t_pulse();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule